// File: doc/BRIEF.md
# Phase Lock Window Detector

This block judges whether a motor's feedback tick is keeping phase with a reference tick. It counts the clock cycles from each rising edge of the reference pulse to the next rising edge of the motor pulse, such as a speed tick derived from back-EMF. It compares that gap against a window chosen by a 2-bit threshold select. The windows are 6.4, 12.8, 25.6 and 51.2 microseconds at a 10 MHz system clock.

A lock status is raised only after a run of consecutive in-window comparisons. It falls on the first comparison outside the window. The most recent measured gap is also presented as an output. A missing motor edge is counted as a saturated, out-of-window measurement. The block does not contain the loop filter or any speed control; it only reports lock status to them.

Both pulse inputs are taken as synchronous to the clock. A pulse held high counts as a single edge.

Top module: `pld_lock_window`

## Requirements
- R1: A synchronous active-high reset clears `lock` to 0 and `err_cycles` to 0. It also discards any pending measurement.
- R2: The measured error is the number of clock cycles from the cycle in which a reference rising edge is sampled to the cycle in which the next motor rising edge is sampled. It appears on `err_cycles` one cycle after that motor edge is sampled.
- R3: `thr_sel` codes 0, 1, 2 and 3 select windows of 64, 128, 256 and 512 cycles. A comparison is in window when its error is less than or equal to the selected width.
- R4: `lock` rises one cycle after the LOCK_RUN-th consecutive in-window comparison, where LOCK_RUN defaults to 4. It never rises earlier.
- R5: The first out-of-window comparison clears `lock` one cycle later and restarts the consecutive count.
- R6: If a new reference edge arrives while a measurement is still pending, a comparison is made with the saturated error 1023 (2^CNT_W-1). A new measurement then starts at that reference edge.
- R7: A pending measurement that reaches 1023 cycles without a motor edge produces a comparison with error 1023, which is always out of window.
- R8: A motor rising edge with no pending measurement makes no comparison. `lock` and `err_cycles` are unchanged.
- R9: A reference edge and a motor edge sampled in the same cycle make one comparison with error 0. Any measurement pending before that cycle is dropped.
- R10: Between comparisons, `lock` and `err_cycles` hold their values. A change of `thr_sel` alone does not alter `lock`.
- R11: Only rising edges count. A reference pulse held high for many cycles starts exactly one measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (10 MHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Reference tick; rising edge starts a measurement |
| mot_pulse | input | 1 | Motor feedback tick; rising edge ends a measurement |
| thr_sel | input | 2 | Window select: 64, 128, 256 or 512 cycles |
| lock | output | 1 | Phase lock status |
| err_cycles | output | 10 | Most recent measured phase error in cycles |

## Verification
Two events can land in the same cycle: a reference edge that starts a new measurement, and a motor edge that ends the pending one or is coincident with the new reference. The bench provokes this directly with zero-offset pairs. It also sends a second reference edge while a measurement is still pending, then a motor edge a few cycles later. These results are judged against a per-cycle model built on edge timestamps rather than a running counter. The model must show a single zero-error comparison for coincident edges, and a saturated comparison followed by a fresh measurement for a superseding reference edge.

// File: rtl/pld_pkg.sv
package pld_pkg;

  // Window width in cycles for a select code: doubles per step.
  function automatic int win_limit(input logic [1:0] sel, input int base);
    return base << sel;
  endfunction

  // In-window test: error no larger than the selected width.
  function automatic logic in_window(input int err, input logic [1:0] sel, input int base);
    return err <= win_limit(sel, base);
  endfunction

endpackage

// File: rtl/pld_rise.sv
module pld_rise (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  assign rise = d & ~q;
endmodule

// File: rtl/pld_gap_meter.sv
module pld_gap_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_rise,
  input  logic             mot_rise,
  output logic             cmp_valid,
  output logic [CNT_W-1:0] cmp_err
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic             armed;
  logic [CNT_W-1:0] gap;
  logic             timeout;

  assign timeout = armed && (gap == SAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      gap   <= '0;
    end else if (ref_rise) begin
      armed <= !mot_rise;
      gap   <= CNT_W'(1);
    end else if (armed) begin
      if (mot_rise || timeout) armed <= 1'b0;
      else                     gap   <= gap + CNT_W'(1);
    end
  end

  always_comb begin
    cmp_valid = 1'b0;
    cmp_err   = SAT;
    if (ref_rise) begin
      if (mot_rise) begin
        cmp_valid = 1'b1;
        cmp_err   = '0;
      end else if (armed) begin
        cmp_valid = 1'b1;
        cmp_err   = SAT;
      end
    end else if (armed) begin
      if (mot_rise) begin
        cmp_valid = 1'b1;
        cmp_err   = gap;
      end else if (timeout) begin
        cmp_valid = 1'b1;
        cmp_err   = SAT;
      end
    end
  end
endmodule

// File: rtl/pld_lock_qual.sv
module pld_lock_qual #(
  parameter int CNT_W    = 10,
  parameter int LOCK_RUN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_valid,
  input  logic             cmp_in,
  input  logic [CNT_W-1:0] cmp_err,
  output logic             lock,
  output logic [CNT_W-1:0] err_cycles
);
  localparam int SW = $clog2(LOCK_RUN + 1);
  localparam logic [SW-1:0] RUN_MAX  = SW'(LOCK_RUN);
  localparam logic [SW-1:0] RUN_LAST = SW'(LOCK_RUN - 1);

  logic [SW-1:0] streak;

  always_ff @(posedge clk) begin
    if (rst) begin
      streak     <= '0;
      lock       <= 1'b0;
      err_cycles <= '0;
    end else if (cmp_valid) begin
      err_cycles <= cmp_err;
      if (cmp_in) begin
        if (streak != RUN_MAX) streak <= streak + SW'(1);
        lock <= (streak >= RUN_LAST);
      end else begin
        streak <= '0;
        lock   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pld_lock_window.sv
module pld_lock_window #(
  parameter int CNT_W    = 10,
  parameter int BASE_CYC = 64,
  parameter int LOCK_RUN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pulse,
  input  logic             mot_pulse,
  input  logic [1:0]       thr_sel,
  output logic             lock,
  output logic [CNT_W-1:0] err_cycles
);
  localparam int NCH = 2;

  logic [NCH-1:0]   raw;
  logic [NCH-1:0]   rise;
  logic             ref_rise;
  logic             mot_rise;
  logic             cmp_valid;
  logic             cmp_in;
  logic [CNT_W-1:0] cmp_err;

  assign raw = {mot_pulse, ref_pulse};

  for (genvar g = 0; g < NCH; g++) begin : g_edge
    pld_rise u_rise (
      .clk  (clk),
      .rst  (rst),
      .d    (raw[g]),
      .rise (rise[g])
    );
  end

  assign ref_rise = rise[0];
  assign mot_rise = rise[1];

  pld_gap_meter #(.CNT_W(CNT_W)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .ref_rise  (ref_rise),
    .mot_rise  (mot_rise),
    .cmp_valid (cmp_valid),
    .cmp_err   (cmp_err)
  );

  assign cmp_in = pld_pkg::in_window(int'(cmp_err), thr_sel, BASE_CYC);

  pld_lock_qual #(.CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .cmp_valid  (cmp_valid),
    .cmp_in     (cmp_in),
    .cmp_err    (cmp_err),
    .lock       (lock),
    .err_cycles (err_cycles)
  );
endmodule

// File: rtl/pld_lock_window_chk.sv
module pld_lock_window_chk #(
  parameter int CNT_W    = 10,
  parameter int LOCK_RUN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             lock,
  input logic [CNT_W-1:0] err_cycles,
  input logic             cmp_valid,
  input logic             cmp_in,
  input logic [CNT_W-1:0] cmp_err
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  int run_seen;

  always_ff @(posedge clk) begin
    if (rst) run_seen <= 0;
    else if (cmp_valid) begin
      if (!cmp_in)                  run_seen <= 0;
      else if (run_seen < LOCK_RUN) run_seen <= run_seen + 1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!lock && err_cycles == '0));

  assert_rise_after_cmp_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(cmp_valid && cmp_in));

  assert_run_length_R4: assert property (@(posedge clk) disable iff (rst)
    lock |-> run_seen >= LOCK_RUN);

  assert_drop_on_miss_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_in) |=> !lock);

  assert_sat_out_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_err == SAT) |-> !cmp_in);

  assert_hold_lock_R10: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(lock));

  assert_hold_err_R10: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(err_cycles));
endmodule

bind pld_lock_window pld_lock_window_chk #(.CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lock       (lock),
  .err_cycles (err_cycles),
  .cmp_valid  (cmp_valid),
  .cmp_in     (cmp_in),
  .cmp_err    (cmp_err)
);

// File: tb/pld_lock_window_bench.sv
module pld_lock_window_bench;
  localparam int CW  = 10;
  localparam int SAT = (1 << CW) - 1;
  localparam int RUN = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_i = 1'b0;
  logic          mot_i = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic          lock;
  logic [CW-1:0] err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // timestamp-based model state
  int m_cyc = 0, m_start = 0, m_streak = 0, m_err = 0;
  bit m_lock = 0, m_pend = 0, m_rp = 0, m_mp = 0;

  always #4 clk = ~clk;

  pld_lock_window u_pld_lock_window (
    .clk(clk), .rst(rst), .ref_pulse(ref_i), .mot_pulse(mot_i),
    .thr_sel(sel), .lock(lock), .err_cycles(err)
  );

  function automatic int width_of(input logic [1:0] s);
    case (s)
      2'd0: return 64;
      2'd1: return 128;
      2'd2: return 256;
      default: return 512;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic judge(input int e);
    m_err = e;
    if (e <= width_of(sel)) begin
      if (m_streak < RUN) m_streak++;
      m_lock = (m_streak >= RUN);
    end else begin
      m_streak = 0;
      m_lock   = 0;
    end
  endtask

  task automatic model_step(input bit r, input bit m);
    bit rr, mr;
    m_cyc++;
    if (rst) begin
      m_rp = 0; m_mp = 0; m_pend = 0; m_lock = 0; m_err = 0; m_streak = 0;
      return;
    end
    rr = r && !m_rp;
    mr = m && !m_mp;
    m_rp = r; m_mp = m;
    if (rr && mr) begin
      m_pend = 0; judge(0);
    end else if (rr) begin
      if (m_pend) judge(SAT);
      m_pend = 1; m_start = m_cyc;
    end else if (mr && m_pend) begin
      m_pend = 0; judge(m_cyc - m_start);
    end else if (m_pend && (m_cyc - m_start) == SAT) begin
      m_pend = 0; judge(SAT);
    end
  endtask

  // One clock: compare previous result, drive, let the edge pass, update model.
  task automatic cyc(input bit r, input bit m);
    @(negedge clk);
    check("R2 R4 R5 per-cycle lock", int'(lock), int'(m_lock));
    check("R2 R6 R7 per-cycle err", int'(err), m_err);
    ref_i = r; mot_i = m;
    @(posedge clk);
    #1 model_step(r, m);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0);
  endtask

  // reference rises at offset 0 for rw cycles; motor rises at offset k if use_m
  task automatic pair(input int k, input int rw, input bit use_m);
    int last;
    last = ((k + 2) > rw ? (k + 2) : rw) + 2;
    for (int i = 0; i <= last; i++)
      cyc(i < rw, use_m && i >= k && i < k + 2);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7351);
    rst = 1'b1;
    cyc(0, 0); cyc(1, 0); cyc(0, 0);
    rst = 1'b0;
    check("R1 lock after reset", int'(lock), 0);
    check("R1 err after reset", int'(err), 0);

    sel = 2'd0;
    pair(37, 2, 1);
    check("R2 err gap 37", int'(err), 37);
    pair(64, 2, 1); pair(64, 2, 1);
    check("R4 no lock after 3", int'(lock), 0);
    pair(64, 2, 1);
    check("R3 R4 lock at 64 boundary", int'(lock), 1);
    pair(65, 2, 1);
    check("R3 R5 err 65 drops lock", int'(lock), 0);
    check("R2 err 65", int'(err), 65);

    sel = 2'd1;
    repeat (4) pair(128, 2, 1);
    check("R3 lock at 128", int'(lock), 1);
    sel = 2'd0;
    idle(20);
    check("R10 sel change keeps lock", int'(lock), 1);
    check("R10 err held", int'(err), 128);
    sel = 2'd1;
    pair(129, 2, 1);
    check("R3 R5 129 out for sel1", int'(lock), 0);

    sel = 2'd3;
    repeat (4) pair(512, 2, 1);
    check("R3 lock at 512", int'(lock), 1);
    pair(513, 2, 1);
    check("R3 R5 513 out for sel3", int'(lock), 0);

    repeat (4) pair(10, 2, 1);
    cyc(0, 1); cyc(0, 1); cyc(0, 0);
    check("R8 stray motor keeps lock", int'(lock), 1);
    check("R8 stray motor keeps err", int'(err), 10);

    pair(0, 2, 1);
    check("R9 coincident err", int'(err), 0);
    check("R9 coincident lock", int'(lock), 1);

    pair(0, 2, 0);
    idle(20);
    cyc(1, 0);
    check("R6 superseded err", int'(err), SAT);
    check("R6 superseded lock", int'(lock), 0);
    cyc(1, 0); idle(3); cyc(0, 1); cyc(0, 0);
    check("R6 re-armed err", int'(err), 5);

    pair(0, 2, 0);
    idle(1100);
    check("R7 timeout err", int'(err), SAT);
    check("R7 timeout lock", int'(lock), 0);

    pair(40, 300, 1);
    check("R11 held reference err", int'(err), 40);

    for (int t = 0; t < 80; t++) begin
      int k, mode;
      sel  = 2'($urandom_range(0, 3));
      mode = $urandom_range(0, 9);
      if (mode < 6)       k = $urandom_range(0, 80);
      else if (mode < 8)  k = $urandom_range(0, 600);
      else                k = 0;
      pair(k, $urandom_range(1, 4), mode != 9);
      idle($urandom_range(0, 30));
    end
    rst = 1'b1;
    cyc(0, 0);
    rst = 1'b0;
    cyc(0, 0);
    check("R1 mid-run reset lock", int'(lock), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule